// File: doc/BRIEF.md
# Symbol Cell Address Generator with Cursor Inversion

This unit sits in the pixel path of a display that is built from a grid of fixed-size symbols, 20 columns by 15 rows. For each symbol cell that the video side asks for, it first reads a small index RAM to find out which glyph occupies that cell. It then turns the returned glyph base into a full external memory read address for the requested scan line of the glyph. When the 8-bit pixel bytes come back from external memory, it passes each byte through unchanged, or it passes all eight bits inverted if the cell that produced the read is the cell under the cursor.

The cursor position is loaded only on a frame-start pulse, so a cell is never partly inverted within one frame. External memory may answer after a varying delay. The inversion decision for every read is therefore queued when the read is issued and taken off the queue when its data returns. Reads must return in the order they were issued, and no more than `FIFO_DEPTH` reads may be outstanding at one time.

Top module: `sym_cursor_inv`

## Requirements
- R1: One cycle after `req_valid_i` is sampled high, `idx_rd_o` is high and `idx_addr_o` equals 20 × `cell_row_i` + `cell_col_i` for that request, a value in 0..299.
- R2: The index RAM returns its 13-bit word on `idx_data_i` in the cycle after `idx_rd_o` is high. `mem_rd_o` is high two cycles after `idx_rd_o`, and `mem_addr_o` is {bank[23:22] = `MEM_BANK`, glyph base[21:9], half[8], offset[7:0]}.
- R3: For scan lines 0..15 the half bit is 0 and the offset is line × 16. For scan lines 16..31 the half bit is 1 and the offset is (line − 16) × 16. This applies at every cell, including the corners (0,0) and (14,19).
- R4: `pix_valid_o` is high exactly in the cycle after a cycle in which `mem_data_valid_i` is high, and low at all other times.
- R5: `pix_o` is the bitwise NOT of all 8 bits of `mem_data_i` when the request that caused the read matched the stored cursor row and column. Otherwise it equals `mem_data_i`.
- R6: The inversion decisions stay paired with their data bytes, in issue order, when the read latency varies from read to read, with up to `FIFO_DEPTH` reads outstanding.
- R7: The stored cursor changes only on a cycle in which `frame_start_i` is high, and takes its value from `cursor_row_i` and `cursor_col_i`. A request sampled in that same cycle still uses the old cursor. A change on the cursor inputs without the pulse has no effect.
- R8: While `rst` is high, `idx_rd_o`, `mem_rd_o` and `pix_valid_o` are low. After reset the stored cursor is row 0, column 0.
- R9: A new request may be accepted on every cycle, and each request produces its own index read, memory read and pixel byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-start pulse that loads the cursor position |
| cursor_row_i | input | 4 | Cursor row, loaded on frame start |
| cursor_col_i | input | 5 | Cursor column, loaded on frame start |
| req_valid_i | input | 1 | Request for one cell and scan line |
| cell_row_i | input | 4 | Symbol row of the request (0..14) |
| cell_col_i | input | 5 | Symbol column of the request (0..19) |
| line_i | input | 5 | Scan line inside the symbol (0..31) |
| idx_rd_o | output | 1 | Index RAM read strobe |
| idx_addr_o | output | 9 | Index RAM address |
| idx_data_i | input | 13 | Glyph base returned by the index RAM |
| mem_rd_o | output | 1 | External memory read strobe |
| mem_addr_o | output | 24 | External memory read address |
| mem_data_valid_i | input | 1 | Returned pixel byte is valid |
| mem_data_i | input | 8 | Returned pixel byte |
| pix_valid_o | output | 1 | Output pixel byte is valid |
| pix_o | output | 8 | Pixel byte, inverted for the cursor cell |

## Verification
Several properties are checked on every cycle. Each stage strobe must follow the one before it at the fixed distance. Index addresses must stay inside the grid, the bank field must be constant, and the low offset bits must be clear. The flag queue must never overflow or underflow, and every returned byte must produce exactly one output byte in the next cycle. Some behaviour can only be shown by the bench scenarios: that the correct glyph base and half-row offset reach the address, that the correct bytes are inverted when the latency varies, and that a cursor change takes effect only on the frame-start pulse, including a pulse that arrives in the same cycle as a request.

// File: rtl/sym_inv_pkg.sv
package sym_inv_pkg;

    localparam int GRID_COLS = 20;
    localparam int GRID_ROWS = 15;
    localparam int CELLS     = GRID_COLS * GRID_ROWS;
    localparam int ROW_W     = $clog2(GRID_ROWS);
    localparam int COL_W     = $clog2(GRID_COLS);
    localparam int CELL_AW   = $clog2(CELLS);
    localparam int BASE_W    = 13;
    localparam int LINE_W    = 5;
    localparam int OFF_W     = 8;
    localparam int OFF_SHIFT = OFF_W - (LINE_W - 1);
    localparam int BANK_W    = 2;
    localparam int MEM_AW    = BANK_W + BASE_W + 1 + OFF_W;
    localparam int PIX_W     = 8;

    // Per-request tag carried down the address pipeline
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              inv;
    } cell_tag_t;

    // External memory address layout
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BASE_W-1:0] base;
        logic              half;
        logic [OFF_W-1:0]  off;
    } mem_addr_t;

    function automatic logic [CELL_AW-1:0] cell_index(
        input logic [ROW_W-1:0] r,
        input logic [COL_W-1:0] c
    );
        return CELL_AW'(r) * CELL_AW'(GRID_COLS) + CELL_AW'(c);
    endfunction

    function automatic mem_addr_t glyph_addr(
        input logic [BANK_W-1:0] bank,
        input logic [BASE_W-1:0] base,
        input logic [LINE_W-1:0] line
    );
        mem_addr_t a;
        a.bank = bank;
        a.base = base;
        a.half = line[LINE_W-1];
        a.off  = OFF_W'(line[LINE_W-2:0]) << OFF_SHIFT;
        return a;
    endfunction

endpackage

// File: rtl/sym_cursor_reg.sv
module sym_cursor_reg
    import sym_inv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic [ROW_W-1:0] cursor_row_i,
    input  logic [COL_W-1:0] cursor_col_i,
    input  logic [ROW_W-1:0] cell_row_i,
    input  logic [COL_W-1:0] cell_col_i,
    output logic             match_o
);

    logic [ROW_W-1:0] cur_row_q;
    logic [COL_W-1:0] cur_col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row_q <= '0;
            cur_col_q <= '0;
        end else if (frame_start_i) begin
            cur_row_q <= cursor_row_i;
            cur_col_q <= cursor_col_i;
        end
    end

    assign match_o = (cell_row_i == cur_row_q) && (cell_col_i == cur_col_q);

    // R7: stored position only follows the inputs across a frame pulse
    p_cursor_load_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start_i |=> (cur_row_q == $past(cursor_row_i)) && (cur_col_q == $past(cursor_col_i)));

endmodule

// File: rtl/sym_addr_pipe.sv
module sym_addr_pipe
    import sym_inv_pkg::*;
#(
    parameter logic [BANK_W-1:0] MEM_BANK = 2'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid_i,
    input  logic [ROW_W-1:0]   cell_row_i,
    input  logic [COL_W-1:0]   cell_col_i,
    input  logic [LINE_W-1:0]  line_i,
    input  logic               match_i,
    output logic               idx_rd_o,
    output logic [CELL_AW-1:0] idx_addr_o,
    input  logic [BASE_W-1:0]  idx_data_i,
    output logic               mem_rd_o,
    output logic [MEM_AW-1:0]  mem_addr_o,
    output logic               push_o,
    output logic               push_flag_o
);

    logic         s1_v_q, s2_v_q, s3_v_q;
    cell_tag_t    s1_tag_q, s2_tag_q;
    logic [CELL_AW-1:0] idx_q;
    mem_addr_t    addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v_q <= 1'b0;
            s2_v_q <= 1'b0;
            s3_v_q <= 1'b0;
        end else begin
            s1_v_q <= req_valid_i;
            s2_v_q <= s1_v_q;
            s3_v_q <= s2_v_q;
        end
    end

    // Data registers carry no reset; validity is tracked above
    always_ff @(posedge clk) begin
        idx_q         <= cell_index(cell_row_i, cell_col_i);
        s1_tag_q.line <= line_i;
        s1_tag_q.inv  <= match_i;
        s2_tag_q      <= s1_tag_q;
        addr_q        <= glyph_addr(MEM_BANK, idx_data_i, s2_tag_q.line);
    end

    assign idx_rd_o    = s1_v_q;
    assign idx_addr_o  = idx_q;
    assign mem_rd_o    = s3_v_q;
    assign mem_addr_o  = addr_q;
    assign push_o      = s2_v_q;
    assign push_flag_o = s2_tag_q.inv;

    p_idx_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> idx_rd_o);
    p_idx_in_grid_r1: assert property (@(posedge clk) disable iff (rst)
        idx_rd_o |-> (int'(idx_addr_o) < CELLS));
    p_mem_follows_idx_r2: assert property (@(posedge clk) disable iff (rst)
        idx_rd_o |=> ##1 mem_rd_o);
    p_mem_bank_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (mem_addr_o[MEM_AW-1 -: BANK_W] == MEM_BANK));
    p_offset_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (mem_addr_o[OFF_SHIFT-1:0] == '0));

endmodule

// File: rtl/sym_flag_fifo.sv
module sym_flag_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_i) wr_q <= step(wr_q);
            if (pop_i)  rd_q <= step(rd_q);
            case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) slot_q[wr_q] <= push_data_i;
    end

    assign head_o = slot_q[rd_q];

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |-> (int'(count_q) < DEPTH));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (count_q != '0));

endmodule

// File: rtl/sym_cursor_inv.sv
module sym_cursor_inv
    import sym_inv_pkg::*;
#(
    parameter logic [1:0] MEM_BANK   = 2'd1,
    parameter int         FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start_i,
    input  logic [3:0]  cursor_row_i,
    input  logic [4:0]  cursor_col_i,
    input  logic        req_valid_i,
    input  logic [3:0]  cell_row_i,
    input  logic [4:0]  cell_col_i,
    input  logic [4:0]  line_i,
    output logic        idx_rd_o,
    output logic [8:0]  idx_addr_o,
    input  logic [12:0] idx_data_i,
    output logic        mem_rd_o,
    output logic [23:0] mem_addr_o,
    input  logic        mem_data_valid_i,
    input  logic [7:0]  mem_data_i,
    output logic        pix_valid_o,
    output logic [7:0]  pix_o
);

    logic             match;
    logic             push, push_flag;
    logic [0:0]       head_flag;
    logic [PIX_W-1:0] pix_next;
    logic             pix_valid_q;
    logic [PIX_W-1:0] pix_q;

    sym_cursor_reg u_cursor (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start_i),
        .cursor_row_i  (cursor_row_i),
        .cursor_col_i  (cursor_col_i),
        .cell_row_i    (cell_row_i),
        .cell_col_i    (cell_col_i),
        .match_o       (match)
    );

    sym_addr_pipe #(.MEM_BANK(MEM_BANK)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid_i),
        .cell_row_i  (cell_row_i),
        .cell_col_i  (cell_col_i),
        .line_i      (line_i),
        .match_i     (match),
        .idx_rd_o    (idx_rd_o),
        .idx_addr_o  (idx_addr_o),
        .idx_data_i  (idx_data_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .push_o      (push),
        .push_flag_o (push_flag)
    );

    sym_flag_fifo #(.DEPTH(FIFO_DEPTH), .W(1)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .push_data_i (push_flag),
        .pop_i       (mem_data_valid_i),
        .head_o      (head_flag)
    );

    for (genvar b = 0; b < PIX_W; b++) begin : g_inv
        assign pix_next[b] = mem_data_i[b] ^ head_flag[0];
    end

    always_ff @(posedge clk) begin
        if (rst) pix_valid_q <= 1'b0;
        else     pix_valid_q <= mem_data_valid_i;
    end

    always_ff @(posedge clk) begin
        if (mem_data_valid_i) pix_q <= pix_next;
    end

    assign pix_valid_o = pix_valid_q;
    assign pix_o       = pix_q;

    p_pix_follows_data_r4: assert property (@(posedge clk) disable iff (rst)
        mem_data_valid_i |=> pix_valid_o);
    p_pix_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_data_valid_i |=> !pix_valid_o);

endmodule

// File: tb/sym_cursor_inv_tb_top.sv
module sym_cursor_inv_tb_top;

    localparam logic [1:0] BANK  = 2'd1;
    localparam int         LIMIT = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start_i = 1'b0;
    logic [3:0]  cursor_row_i = '0;
    logic [4:0]  cursor_col_i = '0;
    logic        req_valid_i = 1'b0;
    logic [3:0]  cell_row_i = '0;
    logic [4:0]  cell_col_i = '0;
    logic [4:0]  line_i = '0;
    logic        idx_rd_o;
    logic [8:0]  idx_addr_o;
    logic [12:0] idx_data_i = '0;
    logic        mem_rd_o;
    logic [23:0] mem_addr_o;
    logic        mem_data_valid_i = 1'b0;
    logic [7:0]  mem_data_i = '0;
    logic        pix_valid_o;
    logic [7:0]  pix_o;

    sym_cursor_inv #(.MEM_BANK(BANK), .FIFO_DEPTH(8)) dut_i (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string stag = "R1";

    // Reference expectations indexed by cycle
    bit       exp_idx_v [0:LIMIT+8];
    int       exp_idx_a [0:LIMIT+8];
    bit       exp_mem_v [0:LIMIT+8];
    int       exp_mem_a [0:LIMIT+8];
    bit       exp_pix_v [0:LIMIT+8];
    int       pix_q [$];
    int       mq_ready [$];
    int       mq_data [$];
    int       last_ready = 0;
    int       mem_lat = 2;
    bit       var_lat = 1'b0;
    bit       last_rd = 1'b0;
    int       last_addr = 0;
    int       cur_r = 0, cur_c = 0;

    function automatic int ram_word(int a);
        return (a * 37 + 5) % 8192;
    endfunction

    function automatic int mdata(int a);
        return ((a ^ (a >> 8) ^ (a >> 16)) & 255) ^ 8'h5A;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s (%s) actual %0h expected %0h at cycle %0d", tag, what, stag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Per-cycle comparison plus index RAM and external memory models
    always @(negedge clk) begin
        if (!done) begin
            if (cyc > LIMIT) begin
                errors++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                done = 1'b1;
                finish_run();
            end
            chk("R1", int'(idx_rd_o), int'(exp_idx_v[cyc]), "index read strobe");
            if (idx_rd_o && exp_idx_v[cyc])
                chk("R1", int'(idx_addr_o), exp_idx_a[cyc], "index address");
            chk("R2", int'(mem_rd_o), int'(exp_mem_v[cyc]), "memory read strobe");
            if (mem_rd_o && exp_mem_v[cyc])
                chk("R2", int'(mem_addr_o), exp_mem_a[cyc], "memory address");
            chk("R4", int'(pix_valid_o), int'(exp_pix_v[cyc]), "pixel valid timing");
            if (pix_valid_o) begin
                if (pix_q.size() == 0) chk("R5", int'(pix_o), -1, "pixel with no pending request");
                else chk("R5", int'(pix_o), pix_q.pop_front(), "pixel byte");
            end
            // index RAM: word valid the cycle after the read strobe
            idx_data_i = last_rd ? 13'(ram_word(last_addr)) : 13'd0;
            last_rd    = idx_rd_o;
            last_addr  = int'(idx_addr_o);
            // external memory: in-order return, per-read latency
            if (mem_rd_o) begin
                int lat = var_lat ? ((cyc * 7) % 5) + 1 : mem_lat;
                int rdy = cyc + lat;
                if (rdy <= last_ready) rdy = last_ready + 1;
                last_ready = rdy;
                mq_ready.push_back(rdy);
                mq_data.push_back(mdata(int'(mem_addr_o)));
            end
            if (mq_ready.size() > 0 && mq_ready[0] <= cyc) begin
                void'(mq_ready.pop_front());
                mem_data_valid_i = 1'b1;
                mem_data_i       = 8'(mq_data.pop_front());
                exp_pix_v[cyc+1] = 1'b1;
            end else begin
                mem_data_valid_i = 1'b0;
                mem_data_i       = 8'h00;
            end
        end
    end

    // Drive one request at the current falling edge and record its expectations
    task automatic issue(int r, int c, int ln);
        int idx, addr, inv;
        req_valid_i = 1'b1;
        cell_row_i  = 4'(r);
        cell_col_i  = 5'(c);
        line_i      = 5'(ln);
        idx  = 20 * r + c;
        addr = (int'(BANK) << 22) | (ram_word(idx) << 9) | (((ln >> 4) & 1) << 8) | ((ln & 15) << 4);
        inv  = (r == cur_r && c == cur_c) ? 8'hFF : 8'h00;
        exp_idx_v[cyc+1] = 1'b1;
        exp_idx_a[cyc+1] = idx;
        exp_mem_v[cyc+3] = 1'b1;
        exp_mem_a[cyc+3] = addr;
        pix_q.push_back(mdata(addr) ^ inv);
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic pulse_frame(int r, int c);
        cursor_row_i  = 4'(r);
        cursor_col_i  = 5'(c);
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        cur_r = r;
        cur_c = c;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R8: outputs quiet while reset is held
        stag = "R8";
        repeat (3) begin
            @(negedge clk);
            chk("R8", int'(idx_rd_o), 0, "index strobe in reset");
            chk("R8", int'(mem_rd_o), 0, "memory strobe in reset");
            chk("R8", int'(pix_valid_o), 0, "pixel valid in reset");
        end
        rst = 1'b0;
        idle(2);
        // R8: cursor defaults to cell (0,0) after reset
        issue(0, 0, 0);
        issue(0, 1, 0);
        idle(10);

        // R5: one row swept with the cursor in its middle
        stag = "R5";
        pulse_frame(3, 7);
        for (int c = 0; c < 20; c++) issue(3, c, c);
        idle(10);

        // R3: half-row select and offset at the line boundaries and grid corners
        stag = "R3";
        issue(14, 19, 0);
        issue(14, 19, 15);
        issue(14, 19, 16);
        issue(14, 19, 31);
        issue(0, 0, 16);
        idle(10);

        // R7: input change without pulse is ignored; pulse with request uses old cursor
        stag = "R7";
        cursor_row_i = 4'd5;
        cursor_col_i = 5'd5;
        idle(2);
        issue(5, 5, 1);
        issue(3, 7, 1);
        idle(3);
        cursor_row_i  = 4'd9;
        cursor_col_i  = 5'd9;
        frame_start_i = 1'b1;
        issue(9, 9, 2);
        frame_start_i = 1'b0;
        cur_r = 9;
        cur_c = 9;
        issue(9, 9, 2);
        issue(3, 7, 2);
        idle(10);

        // R6: latency differs from read to read
        stag = "R6";
        var_lat = 1'b1;
        pulse_frame(4, 12);
        for (int i = 0; i < 24; i++) issue(i % 15, (i * 3) % 20, i % 32);
        idle(12);

        // R9: requests on every cycle with a long fixed latency
        stag = "R9";
        var_lat = 1'b0;
        mem_lat = 5;
        pulse_frame(7, 3);
        for (int i = 0; i < 30; i++) issue((i + 5) % 15, (i * 7) % 20, (i * 5) % 32);

        while (pix_q.size() != 0 || mq_ready.size() != 0) @(negedge clk);
        idle(6);
        done = 1'b1;
        finish_run();
    end

endmodule